// File: doc/BRIEF.md
# Synthesizer programming target with deferred divider commit

This block is a write-only two-wire bus target that runs from a fast system clock. It oversamples SCL and SDA, recognises START and STOP, and answers one 7-bit address out of four. Two strap pins pick which of the four it answers. After a write addressed to it, data bytes go into five registers in a fixed order: divider high, divider low, control A, band, control B. Successive bytes go to successive positions without re-addressing.

A write may begin at the divider pair or at control A. The top bit of the first data byte chooses which. The three control registers take a new value as soon as their byte has been clocked in. The divider behaves differently. Its two bytes are held in staging and move to the output only when the transfer ends with STOP, and only if both bytes arrived in that transfer. A computation window of a set number of system clocks then begins. The valid flag rises at the end of the window. A START seen inside the window leaves the flag low.

The ratio bits sit in control A, which takes effect byte by byte. Any write that changes them must therefore carry both divider bytes in the same transfer.

Top module: `tuner_prog_if`

## Requirements
- R1: The target answers address {BASE_ADDR[6:2], addr_sel} with R/W = 0. The default base of 7'h60 gives 7'h60..7'h63. It acknowledges that address byte and every data byte that follows by driving sda_oe high, which pulls SDA low, during the 9th SCL clock.
- R2: An address byte with another address, or with R/W = 1, gets no acknowledge. The whole transfer then leaves every output register unchanged.
- R3: The MSB of the first data byte picks the starting position. A 0 starts at divider high, and bits 6..0 of that byte are stored. A 1 starts at control A, and the whole byte is stored.
- R4: Positions run in this order: 0 divider high, 1 divider low, 2 control A, 3 band, 4 control B. Each later byte of the same transfer goes to the next position.
- R5: ctrl_a, band and ctrl_b take the new byte on the 8th SCL clock of that byte, before the acknowledge and before any STOP.
- R6: div_value = {divider high[6:0], divider low} is updated only on a STOP. Both divider bytes must have been received since the last START. A transfer that carries only one of them leaves div_value and div_valid unchanged.
- R7: div_valid goes low at a committing STOP. It goes high COMP_CYCLES system clocks later.
- R8: A START detected before the window ends cancels the window. div_valid then stays low until a later committing STOP completes its own window.
- R9: Data bytes after position 4 are acknowledged and discarded. No register changes.
- R10: After reset every register and div_value are zero, div_valid is low and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line level |
| sda | input | 1 | Bus data line level |
| addr_sel | input | 2 | Strap selecting the low two address bits |
| sda_oe | output | 1 | When high, pull SDA low (acknowledge) |
| ctrl_a | output | 8 | Control register A (holds ratio bits) |
| band | output | 8 | Band register |
| ctrl_b | output | 8 | Control register B |
| div_value | output | 15 | Committed main divider |
| div_valid | output | 1 | Divider computation finished without interruption |

## Verification
The first pattern is a full five-byte write starting at the divider. It shows that control A updates before STOP while the divider waits for STOP. A control-first write that runs past the last register separates the two start positions and tests the discard of overflow bytes. A write carrying only divider high tests the both-bytes rule. A START sent inside the window, to another address, separates a cancelled window from a completed one. Address patterns are also tried under two strap settings, including one with the read bit set. They show that acknowledge and register updates happen only for the strapped address in write mode.

// File: rtl/tuner_prog_if.sv
module tuner_prog_if #(
  parameter logic [6:0] BASE_ADDR   = 7'h60,
  parameter int         COMP_CYCLES = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl,
  input  logic        sda,
  input  logic [1:0]  addr_sel,
  output logic        sda_oe,
  output logic [7:0]  ctrl_a,
  output logic [7:0]  band,
  output logic [7:0]  ctrl_b,
  output logic [14:0] div_value,
  output logic        div_valid
);

  localparam int CW     = $clog2(COMP_CYCLES + 1);
  localparam int NREG   = 5;
  localparam logic [2:0] P_DH = 3'd0, P_DL = 3'd1, P_CA = 3'd2, P_BD = 3'd3, P_CB = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} st_t;

  logic [2:0] scl_q, sda_q;
  wire scl_s = scl_q[1], scl_p = scl_q[2];
  wire sda_s = sda_q[1], sda_p = sda_q[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  st_t        st;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic       ack_en, first;
  logic [2:0] ptr;
  logic [6:0] dh_stage;
  logic [7:0] dl_stage;
  logic       got_dh, got_dl;
  logic       busy;
  logic [CW-1:0] cnt;

  wire [6:0] my_addr = {BASE_ADDR[6:2], addr_sel};
  wire [7:0] byte_in = {shreg, sda_s};
  wire       byte_end = scl_rise && bitcnt == 4'd7;
  wire [2:0] wr_idx  = first ? (byte_in[7] ? P_CA : P_DH) : ptr;
  wire       commit  = stop_det && st == S_DATA && got_dh && got_dl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl};
      sda_q <= {sda_q[1:0], sda};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_en   <= 1'b0;
      first    <= 1'b0;
      ptr      <= '0;
      dh_stage <= '0;
      dl_stage <= '0;
      got_dh   <= 1'b0;
      got_dl   <= 1'b0;
      sda_oe   <= 1'b0;
      ctrl_a   <= '0;
      band     <= '0;
      ctrl_b   <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      ack_en <= 1'b0;
      sda_oe <= 1'b0;
      got_dh <= 1'b0;
      got_dl <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      ack_en <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st == S_ADDR || st == S_DATA) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 4'd1;
        end else begin
          bitcnt <= 4'd9;
        end
      end
      if (byte_end && st == S_ADDR) begin
        if (byte_in[7:1] == my_addr && !byte_in[0]) begin
          ack_en <= 1'b1;
          first  <= 1'b1;
          st     <= S_DATA;
        end else begin
          st <= S_SKIP;
        end
      end
      if (byte_end && st == S_DATA) begin
        ack_en <= 1'b1;
        first  <= 1'b0;
        if (wr_idx != 3'(NREG)) ptr <= wr_idx + 3'd1;
        case (wr_idx)
          P_DH: begin dh_stage <= byte_in[6:0]; got_dh <= 1'b1; end
          P_DL: begin dl_stage <= byte_in;      got_dl <= 1'b1; end
          P_CA: ctrl_a <= byte_in;
          P_BD: band   <= byte_in;
          P_CB: ctrl_b <= byte_in;
          default: ;
        endcase
      end
      if (scl_fall && bitcnt == 4'd8 && ack_en) sda_oe <= 1'b1;
      if (scl_fall && bitcnt == 4'd9) begin
        sda_oe <= 1'b0;
        ack_en <= 1'b0;
        bitcnt <= '0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_value <= '0;
      div_valid <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
    end else if (commit) begin
      div_value <= {dh_stage, dl_stage};
      div_valid <= 1'b0;
      busy      <= 1'b1;
      cnt       <= '0;
    end else if (busy && start_det) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == CW'(COMP_CYCLES - 1)) begin
        busy      <= 1'b0;
        div_valid <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

endmodule

// File: rtl/tuner_prog_if_chk.sv
module tuner_prog_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        scl_rise,
  input logic        start_det,
  input logic        stop_det,
  input logic        busy,
  input logic        sda_oe,
  input logic [7:0]  ctrl_a,
  input logic [7:0]  band,
  input logic [7:0]  ctrl_b,
  input logic [14:0] div_value,
  input logic        div_valid
);

  assert_ack_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_ctrl_on_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(ctrl_a) && $stable(band) && $stable(ctrl_b)) |-> $past(scl_rise));

  assert_div_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_value) |-> $past(stop_det));

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_valid) |-> $past(stop_det));

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_valid) |-> $past(busy));

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_det && !stop_det) |=> (!busy && !div_valid));

endmodule

bind tuner_prog_if tuner_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
  .start_det(start_det), .stop_det(stop_det), .busy(busy), .sda_oe(sda_oe),
  .ctrl_a(ctrl_a), .band(band), .ctrl_b(ctrl_b),
  .div_value(div_value), .div_valid(div_valid)
);

// File: tb/sim_tuner_prog_if.sv
`timescale 1ns/1ps
module sim_tuner_prog_if;
  localparam int COMP = 200;
  localparam int Q = 40;

  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1;
  logic [1:0] addr_sel = 2'd2;
  logic sda_oe, div_valid;
  logic [7:0] ctrl_a, band, ctrl_b;
  logic [14:0] div_value;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0, failures = 0;
  bit ack_slot = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  tuner_prog_if #(.BASE_ADDR(7'h60), .COMP_CYCLES(COMP)) u0 (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_line), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .ctrl_a(ctrl_a), .band(band), .ctrl_b(ctrl_b),
    .div_value(div_value), .div_valid(div_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge scl) if (ack_slot) begin
    #4;
    if (exp_q.size() == 0) chk("ack queue empty", 1, 0);
    else begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {31'd0, ~sda_line}, {31'd0, e});
    end
  end

  task automatic do_start();
    m_sda = 1; #Q; scl = 1; #Q; m_sda = 0; #Q; scl = 0; #Q;
  endtask

  task automatic do_stop();
    m_sda = 0; #Q; scl = 1; #Q; m_sda = 1; #Q;
  endtask

  task automatic send(input logic [7:0] b, input bit ack, input string tag);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; scl = 1; #(2*Q); scl = 0; #Q;
    end
    m_sda = 1;
    exp_q.push_back(ack); tag_q.push_back(tag);
    ack_slot = 1; #Q; scl = 1; #(2*Q); scl = 0; ack_slot = 0; #Q;
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clks(5); rst_n = 1; clks(5);
    chk("R10 reset ctrl_a", ctrl_a, 0);
    chk("R10 reset band/ctrl_b", {band, ctrl_b}, 0);
    chk("R10 reset div", {div_value, div_valid, sda_oe}, 0);

    // full write, address 0x62
    do_start();
    send(8'hC4, 1, "R1 own address ack");
    send(8'h12, 1, "R4 data ack");
    send(8'h34, 1, "R4 data ack");
    send(8'h85, 1, "R4 data ack");
    chk("R5 ctrl_a before stop", ctrl_a, 8'h85);
    chk("R6 divider held before stop", div_value, 0);
    send(8'h5A, 1, "R4 data ack");
    send(8'hC3, 1, "R4 data ack");
    do_stop();
    chk("R6 divider committed", div_value, 15'h1234);
    chk("R7 valid low after stop", div_valid, 0);
    clks(COMP - 60);
    chk("R7 valid low inside window", div_valid, 0);
    clks(80);
    chk("R7 valid high after window", div_valid, 1);
    chk("R4 band and ctrl_b", {band, ctrl_b}, 16'h5AC3);

    // other address and read bit
    do_start(); send(8'hC0, 0, "R2 foreign address nack"); send(8'h80, 0, "R2 no ack in foreign transfer"); do_stop();
    do_start(); send(8'hC5, 0, "R2 read bit nack"); do_stop();
    chk("R2 registers untouched", {ctrl_a, band, ctrl_b}, 24'h855AC3);
    chk("R2 divider untouched", {div_value, div_valid}, {15'h1234, 1'b1});

    // control-first partial write, overflow
    do_start();
    send(8'hC4, 1, "R1 ack");
    send(8'hA0, 1, "R3 ctrl first ack");
    send(8'h11, 1, "R3 band ack");
    send(8'h22, 1, "R3 ctrl_b ack");
    send(8'h33, 1, "R9 overflow ack");
    send(8'h44, 1, "R9 overflow ack");
    do_stop();
    chk("R3 R9 control-first contents", {ctrl_a, band, ctrl_b}, 24'hA01122);
    chk("R6 no divider bytes no commit", {div_value, div_valid}, {15'h1234, 1'b1});

    // divider high only
    do_start(); send(8'hC4, 1, "R1 ack"); send(8'h05, 1, "R3 divider first ack"); do_stop();
    clks(10);
    chk("R6 single divider byte ignored", {div_value, div_valid}, {15'h1234, 1'b1});

    // divider then ctrl_a via auto-increment
    do_start(); send(8'hC4, 1, "R1 ack");
    send(8'h7F, 1, "R4 ack"); send(8'hFF, 1, "R4 ack"); send(8'h81, 1, "R4 ack");
    do_stop();
    chk("R4 ctrl_a after divider", ctrl_a, 8'h81);
    chk("R6 divider max", div_value, 15'h7FFF);
    clks(COMP + 40);
    chk("R7 valid after second window", div_valid, 1);

    // cancel inside window
    do_start(); send(8'hC4, 1, "R1 ack"); send(8'h01, 1, "R4 ack"); send(8'h02, 1, "R4 ack"); do_stop();
    clks(20);
    do_start(); send(8'hC0, 0, "R2 foreign nack"); do_stop();
    clks(COMP + 100);
    chk("R8 cancelled window keeps valid low", div_valid, 0);
    chk("R8 value still loaded", div_value, 15'h0102);

    // strap change, recommit
    addr_sel = 2'd0;
    do_start(); send(8'hC4, 0, "R1 old address nack after strap change"); do_stop();
    do_start(); send(8'hC0, 1, "R1 strap 0 ack"); send(8'h03, 1, "R4 ack"); send(8'h04, 1, "R4 ack"); do_stop();
    chk("R6 new commit", div_value, 15'h0304);
    clks(COMP + 40);
    chk("R7 valid after uninterrupted window", div_valid, 1);
    chk("R10 sda released when idle", sda_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule